// File: doc/BRIEF.md
# Protection-Unit Region Register Bank

This block is the software-visible register bank of a memory protection unit. It holds a configurable number of regions, from 0 to 16. Each region has a 32-bit base word and a 32-bit limit word. The bank also holds a region-select register and two 32-bit memory-attribute words. A simple word bus reads and writes these registers. Read data comes back registered, one cycle after the read strobe.

Base and limit words are reached through windows. Each kind of word has one primary window and three alias windows. The primary window addresses the region named by the region-select register. An alias window numbered k (1 to 3) addresses the region whose number is the region-select value with its two low bits replaced by k. A region outside the implemented count reads as zero, and writes to it are dropped. Every accepted base or limit write raises a one-cycle pulse that tells the rest of the chip to discard cached translations. Offsets the bank does not decode raise a one-cycle bad-offset flag.

Top module: `mpu_regbank`

## Requirements
- R1: Reset, asynchronous and active low, clears every base word, every limit word, the region-select register and both attribute words to zero. Afterwards every decoded offset reads as zero.
- R2: A read strobe with no write strobe at edge t gives `bus_rvalid`=1 and `bus_rdata` after edge t, for exactly that one cycle. In every other cycle `bus_rvalid`=0 and `bus_rdata`=0.
- R3: The region-select register sits at offset 0xD98. A write keeps only the low RW bits of the data, where RW=1 for 2 or fewer regions and RW=ceil(log2(regions)) otherwise. A read returns the stored value zero-extended.
- R4: Base windows sit at 0xD9C+8k and limit windows at 0xDA0+8k, for alias k=0..3. A write stores all 32 data bits in the selected region's word, and a read returns that word.
- R5: Alias 0 selects the region in the region-select register. Alias k>0 selects (select & ~3) | k. Base and limit writes never change the region-select register.
- R6: If the selected region index is at or above the region count, a read returns 0, and a write changes nothing and raises no invalidate.
- R7: An accepted base or limit write drives `tlb_inval` high for exactly the one cycle after the write edge. No other access raises it.
- R8: Attribute word 0 sits at 0xDC0 and word 1 at 0xDC4. Both read back what was written, and writes to them never raise `tlb_inval`. With zero regions, writes to them are ignored and they read 0.
- R9: Any other offset, including any offset not word aligned, reads 0 (with `bus_rvalid`) and ignores writes. Such an access drives `bad_offset` high for the one cycle after the access edge.
- R10: When the read and write strobes are high together, the write is performed and no read response is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid, zero otherwise |
| bus_rvalid | output | 1 | Read response, one cycle after a read strobe |
| bad_offset | output | 1 | Undecoded-offset access flag, one cycle |
| tlb_inval | output | 1 | Translation-invalidate pulse after a region write |

## Verification
Some properties are checked on every cycle by assertions:
- a read response appears only after a read-only strobe;
- invalidate pulses follow only write strobes, never follow attribute writes, and never coincide with a bad-offset flag;
- out-of-range region reads and bad-offset reads return zero.

Other behaviour needs the bench's scenarios, because it depends on history held across many accesses. This covers the stored values, the alias substitution of the low region bits, the masking of the region-select register, silently dropped out-of-range writes, the zero-region variant and the clearing done by reset. The bench checks these against a reference model that runs a seeded random mix of accesses alongside directed cases.

// File: rtl/mpu_regbank_pkg.sv
package mpu_regbank_pkg;

   localparam logic [11:0] OFS_RNUM   = 12'hD98;
   localparam logic [11:0] OFS_WIN_LO = 12'hD9C;
   localparam logic [11:0] OFS_WIN_HI = 12'hDB8;
   localparam logic [11:0] OFS_ATTR0  = 12'hDC0;
   localparam logic [11:0] OFS_ATTR1  = 12'hDC4;

   localparam int unsigned MAX_REGIONS = 16;

   typedef enum logic [2:0] {
      ACC_NONE  = 3'd0,
      ACC_RNUM  = 3'd1,
      ACC_BASE  = 3'd2,
      ACC_LIMIT = 3'd3,
      ACC_ATTR0 = 3'd4,
      ACC_ATTR1 = 3'd5
   } acc_kind_e;

   // width of the region-select register for a given region count
   function automatic int unsigned idx_width(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/mpu_addr_decode.sv
module mpu_addr_decode
   import mpu_regbank_pkg::*;
#(
   parameter int unsigned ADDR_W = 12
) (
   input  logic [ADDR_W-1:0] addr,
   output acc_kind_e         kind,
   output logic [1:0]        alias_num
);

   // word offset inside the base/limit window area; bit 0 picks limit,
   // bits [2:1] give the alias number
   logic [2:0] win_off;

   always_comb begin
      kind      = ACC_NONE;
      alias_num = 2'd0;
      win_off   = addr[4:2] - 3'd7;
      if (addr == ADDR_W'(OFS_RNUM)) begin
         kind = ACC_RNUM;
      end else if ((addr >= ADDR_W'(OFS_WIN_LO)) && (addr <= ADDR_W'(OFS_WIN_HI))
                   && (addr[1:0] == 2'b00)) begin
         kind      = win_off[0] ? ACC_LIMIT : ACC_BASE;
         alias_num = win_off[2:1];
      end else if (addr == ADDR_W'(OFS_ATTR0)) begin
         kind = ACC_ATTR0;
      end else if (addr == ADDR_W'(OFS_ATTR1)) begin
         kind = ACC_ATTR1;
      end
   end

endmodule

// File: rtl/mpu_region_select.sv
module mpu_region_select #(
   parameter int unsigned NUM_REGIONS = 8,
   parameter int unsigned RNR_W       = 3,
   parameter int unsigned SEL_W       = 3
) (
   input  logic [RNR_W-1:0] rnum,
   input  logic [1:0]       alias_num,
   output logic [SEL_W-1:0] sel,
   output logic             in_range
);

   logic [SEL_W-1:0] rnum_ext;
   assign rnum_ext = SEL_W'(rnum);

   generate
      if (SEL_W > 2) begin : g_wide
         assign sel = (alias_num != 2'd0) ? {rnum_ext[SEL_W-1:2], alias_num} : rnum_ext;
      end else begin : g_narrow
         assign sel = (alias_num != 2'd0) ? alias_num : rnum_ext;
      end
   endgenerate

   assign in_range = ({{(32-SEL_W){1'b0}}, sel} < 32'(NUM_REGIONS));

endmodule

// File: rtl/mpu_region_store.sv
module mpu_region_store #(
   parameter int unsigned NUM_REGIONS = 8,
   parameter int unsigned SEL_W       = 3,
   parameter int unsigned DATA_W      = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_base,
   input  logic              wr_limit,
   input  logic [SEL_W-1:0]  sel,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] base_rd,
   output logic [DATA_W-1:0] limit_rd
);

   generate
      if (NUM_REGIONS == 0) begin : g_empty
         logic unused_store_in;
         assign unused_store_in = ^{clk, rst_n, wr_base, wr_limit, sel, wdata};
         assign base_rd  = '0;
         assign limit_rd = '0;
      end else begin : g_regions
         logic [DATA_W-1:0] base_q  [NUM_REGIONS];
         logic [DATA_W-1:0] limit_q [NUM_REGIONS];

         for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  base_q[r]  <= '0;
                  limit_q[r] <= '0;
               end else begin
                  if (wr_base && (sel == SEL_W'(r)))
                     base_q[r] <= wdata;
                  if (wr_limit && (sel == SEL_W'(r)))
                     limit_q[r] <= wdata;
               end
            end
         end

         always_comb begin
            base_rd  = '0;
            limit_rd = '0;
            for (int r = 0; r < NUM_REGIONS; r++) begin
               if (sel == SEL_W'(r)) begin
                  base_rd  = base_q[r];
                  limit_rd = limit_q[r];
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/mpu_regbank.sv
module mpu_regbank
   import mpu_regbank_pkg::*;
#(
   parameter int unsigned NUM_REGIONS = 8,
   parameter int unsigned ADDR_W      = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              bus_rvalid,
   output logic              bad_offset,
   output logic              tlb_inval
);

   localparam int unsigned DATA_W = 32;
   localparam int unsigned RNR_W  = idx_width(NUM_REGIONS);
   localparam int unsigned SEL_W  = (RNR_W > 2) ? RNR_W : 2;

   generate
      if (NUM_REGIONS > MAX_REGIONS) begin : g_bad_count
         $error("mpu_regbank: NUM_REGIONS must not exceed 16");
      end
      if (ADDR_W < 12) begin : g_bad_addr
         $error("mpu_regbank: ADDR_W must be at least 12");
      end
   endgenerate

   acc_kind_e         acc_kind;
   logic [1:0]        alias_num;
   logic [RNR_W-1:0]  rnum_q;
   logic [SEL_W-1:0]  sel;
   logic              sel_in_range;
   logic [DATA_W-1:0] base_rd, limit_rd;
   logic [DATA_W-1:0] attr0_q, attr1_q;
   logic [DATA_W-1:0] rd_val;
   logic              rd_en, wr_base, wr_limit, region_wr;

   mpu_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr      (bus_addr),
      .kind      (acc_kind),
      .alias_num (alias_num)
   );

   mpu_region_select #(
      .NUM_REGIONS (NUM_REGIONS),
      .RNR_W       (RNR_W),
      .SEL_W       (SEL_W)
   ) u_sel (
      .rnum      (rnum_q),
      .alias_num (alias_num),
      .sel       (sel),
      .in_range  (sel_in_range)
   );

   assign rd_en     = bus_rd & ~bus_wr;
   assign wr_base   = bus_wr & sel_in_range & (acc_kind == ACC_BASE);
   assign wr_limit  = bus_wr & sel_in_range & (acc_kind == ACC_LIMIT);
   assign region_wr = wr_base | wr_limit;

   mpu_region_store #(
      .NUM_REGIONS (NUM_REGIONS),
      .SEL_W       (SEL_W),
      .DATA_W      (DATA_W)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_base  (wr_base),
      .wr_limit (wr_limit),
      .sel      (sel),
      .wdata    (bus_wdata),
      .base_rd  (base_rd),
      .limit_rd (limit_rd)
   );

   // region-select register: keeps only the index bits
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rnum_q <= '0;
      else if (bus_wr && (acc_kind == ACC_RNUM))
         rnum_q <= bus_wdata[RNR_W-1:0];
   end

   // attribute words exist only when regions are implemented
   generate
      if (NUM_REGIONS > 0) begin : g_attr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               attr0_q <= '0;
               attr1_q <= '0;
            end else begin
               if (bus_wr && (acc_kind == ACC_ATTR0))
                  attr0_q <= bus_wdata;
               if (bus_wr && (acc_kind == ACC_ATTR1))
                  attr1_q <= bus_wdata;
            end
         end
      end else begin : g_no_attr
         assign attr0_q = '0;
         assign attr1_q = '0;
      end
   endgenerate

   always_comb begin
      case (acc_kind)
         ACC_RNUM:  rd_val = DATA_W'(rnum_q);
         ACC_BASE:  rd_val = sel_in_range ? base_rd  : '0;
         ACC_LIMIT: rd_val = sel_in_range ? limit_rd : '0;
         ACC_ATTR0: rd_val = attr0_q;
         ACC_ATTR1: rd_val = attr1_q;
         default:   rd_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata  <= '0;
         bus_rvalid <= 1'b0;
         bad_offset <= 1'b0;
         tlb_inval  <= 1'b0;
      end else begin
         bus_rdata  <= rd_en ? rd_val : '0;
         bus_rvalid <= rd_en;
         bad_offset <= (bus_wr | bus_rd) & (acc_kind == ACC_NONE);
         tlb_inval  <= region_wr;
      end
   end

endmodule

// File: rtl/mpu_regbank_chk.sv
module mpu_regbank_chk
   import mpu_regbank_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        bus_wr,
   input logic        bus_rd,
   input logic [31:0] bus_rdata,
   input logic        bus_rvalid,
   input logic        bad_offset,
   input logic        tlb_inval,
   input acc_kind_e   acc_kind,
   input logic        sel_in_range
);

   a_r2_valid_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rvalid |-> $past(bus_rd && !bus_wr));

   a_r2_read_gets_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_wr) |=> bus_rvalid);

   a_r2_idle_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rvalid |-> (bus_rdata == 32'd0));

   a_r6_out_of_range_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rvalid && $past(!sel_in_range && (acc_kind == ACC_BASE || acc_kind == ACC_LIMIT)))
      |-> (bus_rdata == 32'd0));

   a_r7_inval_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      tlb_inval |-> $past(bus_wr));

   a_r7_inval_not_bad: assert property (@(posedge clk) disable iff (!rst_n)
      !(tlb_inval && bad_offset));

   a_r8_attr_no_inval: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_wr && (acc_kind == ACC_ATTR0 || acc_kind == ACC_ATTR1)) |-> !tlb_inval);

   a_r9_bad_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
      bad_offset |-> $past(bus_wr || bus_rd));

   a_r9_bad_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bad_offset && bus_rvalid) |-> (bus_rdata == 32'd0));

endmodule

bind mpu_regbank mpu_regbank_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_wr       (bus_wr),
   .bus_rd       (bus_rd),
   .bus_rdata    (bus_rdata),
   .bus_rvalid   (bus_rvalid),
   .bad_offset   (bad_offset),
   .tlb_inval    (tlb_inval),
   .acc_kind     (acc_kind),
   .sel_in_range (sel_in_range)
);

// File: tb/sim_mpu_regbank.sv
module sim_mpu_regbank;

   localparam int CLK_PERIOD = 10;
   localparam int NB = 6;          // regions in the main instance
   localparam int RMASK = 7;       // 3 region-select bits for 6 regions

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] rdata0, rdata1;
   logic        rv0, rv1, bad0, bad1, inv0, inv1;

   int nchk = 0, nerr = 0;
   bit done = 0;

   int          m_rnr;
   logic [31:0] m_base [NB];
   logic [31:0] m_limit [NB];
   logic [31:0] m_attr0, m_attr1;
   logic [31:0] s_rd1;
   logic        s_rv1, s_inv1;

   always #(CLK_PERIOD/2) clk = ~clk;

   mpu_regbank #(.NUM_REGIONS(NB), .ADDR_W(12)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata0),
      .bus_rvalid(rv0), .bad_offset(bad0), .tlb_inval(inv0));

   mpu_regbank #(.NUM_REGIONS(0), .ADDR_W(12)) u1 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata1),
      .bus_rvalid(rv1), .bad_offset(bad1), .tlb_inval(inv1));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // 0 undecoded, 1 select, 2 base, 3 limit, 4 attr0, 5 attr1
   function automatic int bkind(input int a, output int al);
      al = 0;
      if (a == 'hD98) return 1;
      for (int k = 0; k < 4; k++) begin
         if (a == 'hD9C + 8*k) begin al = k; return 2; end
         if (a == 'hDA0 + 8*k) begin al = k; return 3; end
      end
      if (a == 'hDC0) return 4;
      if (a == 'hDC4) return 5;
      return 0;
   endfunction

   function automatic int sel_of(input int al);
      return (al == 0) ? m_rnr : ((m_rnr & ~3) | al);
   endfunction

   function automatic logic [31:0] exp_read(input int kind, input int sel);
      case (kind)
         1: return 32'(m_rnr);
         2: return (sel < NB) ? m_base[sel] : 32'd0;
         3: return (sel < NB) ? m_limit[sel] : 32'd0;
         4: return m_attr0;
         5: return m_attr1;
         default: return 32'd0;
      endcase
   endfunction

   task automatic model_reset();
      m_rnr = 0; m_attr0 = '0; m_attr1 = '0;
      for (int i = 0; i < NB; i++) begin m_base[i] = '0; m_limit[i] = '0; end
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic do_op(input bit wr, input bit rd, input int addr,
                        input logic [31:0] data, input string req);
      int al, kind, sel;
      logic [31:0] erd;
      logic ev, eb, ei;
      kind = bkind(addr, al);
      sel  = sel_of(al);
      ev   = rd && !wr;
      erd  = ev ? exp_read(kind, sel) : 32'd0;
      eb   = (wr || rd) && (kind == 0);
      ei   = wr && (kind == 2 || kind == 3) && (sel < NB);
      bus_wr = wr; bus_rd = rd; bus_addr = 12'(addr); bus_wdata = data;
      @(negedge clk);
      chk({req, " rvalid"}, {31'd0, rv0}, {31'd0, ev});
      chk({req, " rdata"}, rdata0, erd);
      chk({req, " bad_offset"}, {31'd0, bad0}, {31'd0, eb});
      chk({req, " tlb_inval"}, {31'd0, inv0}, {31'd0, ei});
      s_rd1 = rdata1; s_rv1 = rv1; s_inv1 = inv1;
      bus_wr = 0; bus_rd = 0;
      if (wr) begin
         case (kind)
            1: m_rnr = int'(data) & RMASK;
            2: if (sel < NB) m_base[sel] = data;
            3: if (sel < NB) m_limit[sel] = data;
            4: m_attr0 = data;
            5: m_attr1 = data;
            default: ;
         endcase
      end
   endtask

   task automatic apply_reset();
      rst_n = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
      model_reset();
      @(negedge clk);
   endtask

   task automatic read_all(input string req);
      do_op(0, 1, 'hD98, 0, req);
      for (int k = 0; k < 4; k++) begin
         do_op(0, 1, 'hD9C + 8*k, 0, req);
         do_op(0, 1, 'hDA0 + 8*k, 0, req);
      end
      do_op(0, 1, 'hDC0, 0, req);
      do_op(0, 1, 'hDC4, 0, req);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(negedge clk);
      // R1: reset state, outputs idle
      chk("R1 rvalid after reset", {31'd0, rv0}, 32'd0);
      chk("R1 inval after reset", {31'd0, inv0}, 32'd0);
      rst_n = 1;
      @(negedge clk);
      read_all("R1");

      // R3: only low 3 bits kept
      do_op(1, 0, 'hD98, 32'hFFFF_FFFD, "R3");
      do_op(0, 1, 'hD98, 0, "R3");
      // R4/R5: primary window writes region 5
      do_op(1, 0, 'hD9C, 32'hDEAD_BEEF, "R4");
      do_op(1, 0, 'hDA0, 32'h1234_5678, "R4");
      do_op(0, 1, 'hD98, 0, "R5 select unchanged");
      do_op(0, 1, 'hD9C, 0, "R4");
      // R6: alias 2 and 3 on select 5 give regions 6 and 7, out of range
      do_op(1, 0, 'hDB0, 32'hAAAA_0001, "R6");
      do_op(1, 0, 'hDB4, 32'hAAAA_0002, "R6");
      do_op(0, 1, 'hDB0, 0, "R6");
      // R5: alias 1 on select 5 gives region 5 (bits 1:0 replaced by 01)
      do_op(0, 1, 'hDA4, 0, "R5");
      // R5: select 1, alias 3 writes region 3
      do_op(1, 0, 'hD98, 32'd1, "R5");
      do_op(1, 0, 'hDB4, 32'h0BAD_F00D, "R5");
      do_op(1, 0, 'hD98, 32'd3, "R5");
      do_op(0, 1, 'hD9C, 0, "R5");
      // R6: select 7 out of range through primary window
      do_op(1, 0, 'hD98, 32'd7, "R6");
      do_op(1, 0, 'hDA0, 32'h5555_5555, "R6");
      do_op(0, 1, 'hDA0, 0, "R6");
      // R8: attribute words, plus zero-region variant
      do_op(1, 0, 'hDC0, 32'hA5A5_0001, "R8");
      chk("R8 zero-region inval", {31'd0, s_inv1}, 32'd0);
      do_op(1, 0, 'hDC4, 32'h5A5A_0002, "R8");
      do_op(0, 1, 'hDC0, 0, "R8");
      chk("R8 zero-region rvalid", {31'd0, s_rv1}, 32'd1);
      chk("R8 zero-region attr read", s_rd1, 32'd0);
      do_op(0, 1, 'hDC4, 0, "R8");
      do_op(1, 0, 'hD9C, 32'h7777_7777, "R6");
      chk("R6 zero-region no inval", {31'd0, s_inv1}, 32'd0);
      // R9: undecoded offsets
      do_op(0, 1, 'hD9E, 0, "R9 unaligned");
      do_op(1, 0, 'hDA2, 32'hFFFF_FFFF, "R9 unaligned");
      do_op(0, 1, 'hDC8, 0, "R9");
      do_op(1, 0, 'h000, 32'h1, "R9");
      do_op(0, 1, 'hD98, 0, "R9 select untouched");
      // R10: both strobes
      do_op(1, 0, 'hD98, 32'd2, "R10");
      do_op(1, 1, 'hD9C, 32'hC0DE_0002, "R10");
      do_op(0, 1, 'hD9C, 0, "R10");

      // random mix
      for (int n = 0; n < 500; n++) begin
         int pick, addr, kk, al, sl;
         bit w, r;
         string tag;
         pick = int'($urandom % 14);
         kk   = int'($urandom % 4);
         case (pick)
            0, 1, 2, 3: addr = 'hD9C + 8*kk;
            4, 5, 6, 7: addr = 'hDA0 + 8*kk;
            8, 9:       addr = 'hD98;
            10:         addr = 'hDC0;
            11:         addr = 'hDC4;
            12:         addr = int'($urandom % 4096);
            default:    addr = 'hD9C + int'($urandom % 32);
         endcase
         w = ($urandom % 2) == 1;
         r = !w || (($urandom % 8) == 0);
         case (bkind(addr, al))
            1: tag = "R3";
            2, 3: begin
               sl = sel_of(al);
               tag = (sl < NB) ? "R4" : "R6";
            end
            4, 5: tag = "R8";
            default: tag = "R9";
         endcase
         if (w && r) tag = "R10";
         do_op(w, r, addr, $urandom, tag);
      end

      // sweep every region through the primary window
      for (int g = 0; g < 8; g++) begin
         do_op(1, 0, 'hD98, 32'(g), "R5");
         do_op(0, 1, 'hD9C, 0, "R4");
         do_op(0, 1, 'hDA0, 0, "R4");
      end

      // R1: reset mid-run clears everything
      apply_reset();
      read_all("R1");
      for (int g = 0; g < NB; g++) begin
         do_op(1, 0, 'hD98, 32'(g), "R1");
         do_op(0, 1, 'hD9C, 0, "R1");
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         nerr++;
         nchk++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

endmodule